// File: doc/BRIEF.md
# 16-bit Arithmetic Unit with Extension Word

This block is the combinational execute stage for a small 16-bit processor. Each operation takes a 5-bit operation code, two 16-bit operands (`b`, the destination operand, and `a`, the source operand) and the current value of a dedicated 16-bit extension word. The extension word carries the side result of the previous arithmetic or shift operation: the carry, the borrow, the high half of a product, the fractional part of a quotient, or the bits pushed out by a shift.

The outputs are the new destination value with a write enable, the new extension word with its own write enable, and a condition flag for the eight test codes. There are also two strobes that tell the surrounding core to step its pair of index registers, and an illegal-operation flag. When a write enable is low, the matching output simply repeats its input (`res_o` repeats `b_i`, `ext_o` repeats `ext_i`). Operand fetch, register writeback and skipping the next instruction all belong to the surrounding core.

Top module: `alu16_ext`

## Requirements
- R1: Codes 0x01 (copy), 0x1E (copy and step up) and 0x1F (copy and step down) write `a_i` to `res_o` and leave the extension word unwritten. 0x1E raises `idx_up_o` only, 0x1F raises `idx_dn_o` only, and the two strobes are never high together.
- R2: 0x02 writes b+a and sets the extension word to 0x0001 on carry out, else 0x0000. 0x03 writes b-a and sets the extension word to 0xFFFF when a > b (unsigned), else 0x0000.
- R3: 0x1A writes the low 16 bits of b+a+ext and sets the extension word to 0x0001 when that sum exceeds 0xFFFF, else 0. 0x1B writes the low 16 bits of b-a+ext and sets the extension word to 0xFFFF when that value is negative, else 0.
- R4: 0x04 (unsigned) and 0x05 (two's complement) write the low half of the 32-bit product and put bits [31:16] of that product in the extension word.
- R5: 0x06 writes the unsigned quotient b/a and sets the extension word to the low 16 bits of (b·65536)/a. 0x07 does the same on two's complement values, truncating toward zero, with 0x8000/0xFFFF giving 0x8000.
- R6: For 0x06, 0x07, 0x08 and 0x09, a zero divisor gives a result of 0. For 0x06 and 0x07 the extension word is also written as 0.
- R7: 0x08 writes the unsigned remainder b mod a, and 0x09 the two's complement remainder, whose sign follows b. Neither writes the extension word.
- R8: 0x0A, 0x0B and 0x0C write b AND a, b OR a and b XOR a, and leave the extension word unwritten.
- R9: 0x0D writes b>>a (logical) with extension ((b·65536)>>a) mod 65536. 0x0F writes (b<<a) mod 65536 with extension bits [31:16] of b<<a. The full 16-bit `a` is the shift count, so counts of 16 or more give zero results.
- R10: 0x0E writes b shifted right arithmetically by a. Its extension word is the low 16 bits of the sign-extended 32-bit value b·65536 shifted arithmetically right by a. Large counts fill with the sign of b.
- R11: Codes 0x10 to 0x17 raise `cond_o` when, in code order, (b&a)!=0, (b&a)==0, b==a, b!=a, b>a unsigned, b>a signed, b<a unsigned, b<a signed. They write nothing. `cond_o` is low for every other code.
- R12: Codes 0x18, 0x19, 0x1C and 0x1D raise `illegal_o`, drop both write enables, and pass `b_i` and `ext_i` through unchanged.
- R13: Code 0x00 drops every write enable, strobe and flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| b_i | input | 16 | Destination operand (current value) |
| a_i | input | 16 | Source operand |
| ext_i | input | 16 | Current extension word |
| res_o | output | 16 | New destination value |
| res_we_o | output | 1 | Destination write enable |
| ext_o | output | 16 | New extension word |
| ext_we_o | output | 1 | Extension word write enable |
| cond_o | output | 1 | Test result for codes 0x10-0x17 |
| idx_up_o | output | 1 | Step index registers up |
| idx_dn_o | output | 1 | Step index registers down |
| illegal_o | output | 1 | Reserved code seen |

## Verification
The hardest cases to reach are the signed-division and arithmetic-shift edges: the most negative dividend over minus one, where the quotient and its fractional extension overflow 16 bits, and shift counts of 16, 31, 32 or near 0xFFFF on a negative operand. Uniform random operands almost never produce these. The stimulus therefore applies them as directed vectors, and in the random phase it biases the divisor and shift count toward zero and small values so that zero-divisor and boundary shifts come up often. Every result goes through a scoreboard whose model uses wide integer arithmetic.

// File: rtl/alu16_ext_pkg.sv
`timescale 1ns/1ps
package alu16_ext_pkg;

  typedef enum logic [4:0] {
    OP_NONE    = 5'h00,
    OP_MOVE    = 5'h01,
    OP_ADD     = 5'h02,
    OP_SUB     = 5'h03,
    OP_MULU    = 5'h04,
    OP_MULS    = 5'h05,
    OP_DIVU    = 5'h06,
    OP_DIVS    = 5'h07,
    OP_REMU    = 5'h08,
    OP_REMS    = 5'h09,
    OP_AND     = 5'h0A,
    OP_OR      = 5'h0B,
    OP_XOR     = 5'h0C,
    OP_SRL     = 5'h0D,
    OP_SRA     = 5'h0E,
    OP_SLL     = 5'h0F,
    OP_TST_ANY = 5'h10,
    OP_TST_NON = 5'h11,
    OP_TST_EQ  = 5'h12,
    OP_TST_NE  = 5'h13,
    OP_TST_GTU = 5'h14,
    OP_TST_GTS = 5'h15,
    OP_TST_LTU = 5'h16,
    OP_TST_LTS = 5'h17,
    OP_RSV_18  = 5'h18,
    OP_RSV_19  = 5'h19,
    OP_ADDC    = 5'h1A,
    OP_SUBC    = 5'h1B,
    OP_RSV_1C  = 5'h1C,
    OP_RSV_1D  = 5'h1D,
    OP_MOVE_UP = 5'h1E,
    OP_MOVE_DN = 5'h1F
  } alu_op_e;

  localparam int TST_COUNT = 8;
  localparam int TST_SEL_W = $clog2(TST_COUNT);

endpackage

// File: rtl/alu16_ext_arith.sv
`timescale 1ns/1ps
module alu16_ext_arith
  import alu16_ext_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   ext_i,
  output logic [W-1:0]   res_o,
  output logic [W-1:0]   ext_o,
  output logic           zero_div_o
);

  localparam int W2 = 2 * W;
  localparam int W3 = 3 * W;

  function automatic logic [W-1:0] udiv_frac(input logic [W-1:0] n, input logic [W-1:0] d);
    logic [W2-1:0] nn;
    nn = {n, {W{1'b0}}};
    return W'(nn / {{W{1'b0}}, d});
  endfunction

  function automatic logic [W-1:0] sdiv_lo(input logic [W-1:0] n, input logic [W-1:0] d);
    logic signed [W2-1:0] nn, dd;
    nn = {{W{n[W-1]}}, n};
    dd = {{W{d[W-1]}}, d};
    return W'(nn / dd);
  endfunction

  function automatic logic [W-1:0] sdiv_frac(input logic [W-1:0] n, input logic [W-1:0] d);
    logic signed [W3-1:0] nn, dd;
    nn = {{W{n[W-1]}}, n, {W{1'b0}}};
    dd = {{W2{d[W-1]}}, d};
    return W'(nn / dd);
  endfunction

  function automatic logic [W-1:0] srem_lo(input logic [W-1:0] n, input logic [W-1:0] d);
    logic signed [W2-1:0] nn, dd;
    nn = {{W{n[W-1]}}, n};
    dd = {{W{d[W-1]}}, d};
    return W'(nn % dd);
  endfunction

  function automatic logic [W2-1:0] mul_signed(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [W2-1:0] xx, yy;
    xx = {{W{x[W-1]}}, x};
    yy = {{W{y[W-1]}}, y};
    return W2'(xx * yy);
  endfunction

  logic           a_nz_w;
  logic [W-1:0]   a_safe_w;
  logic [W:0]     sum1;
  logic [W+1:0]   sum2;
  logic [W2-1:0]  prod;

  assign a_nz_w     = (a_i != '0);
  assign a_safe_w   = a_nz_w ? a_i : W'(1);
  assign zero_div_o = !a_nz_w && (op_i inside {OP_DIVU, OP_DIVS, OP_REMU, OP_REMS});

  always_comb begin
    res_o = b_i;
    ext_o = ext_i;
    sum1  = '0;
    sum2  = '0;
    prod  = '0;
    unique case (op_i)
      OP_ADD: begin
        sum1  = {1'b0, b_i} + {1'b0, a_i};
        res_o = sum1[W-1:0];
        ext_o = {{(W-1){1'b0}}, sum1[W]};
      end
      OP_SUB: begin
        res_o = b_i - a_i;
        ext_o = (a_i > b_i) ? '1 : '0;
      end
      OP_MULU: begin
        prod  = {{W{1'b0}}, b_i} * {{W{1'b0}}, a_i};
        res_o = prod[W-1:0];
        ext_o = prod[W2-1:W];
      end
      OP_MULS: begin
        prod  = mul_signed(b_i, a_i);
        res_o = prod[W-1:0];
        ext_o = prod[W2-1:W];
      end
      OP_DIVU: begin
        res_o = a_nz_w ? (b_i / a_safe_w) : '0;
        ext_o = a_nz_w ? udiv_frac(b_i, a_safe_w) : '0;
      end
      OP_DIVS: begin
        res_o = a_nz_w ? sdiv_lo(b_i, a_safe_w) : '0;
        ext_o = a_nz_w ? sdiv_frac(b_i, a_safe_w) : '0;
      end
      OP_REMU: res_o = a_nz_w ? (b_i % a_safe_w) : '0;
      OP_REMS: res_o = a_nz_w ? srem_lo(b_i, a_safe_w) : '0;
      OP_ADDC: begin
        sum2  = {2'b00, b_i} + {2'b00, a_i} + {2'b00, ext_i};
        res_o = sum2[W-1:0];
        ext_o = (sum2[W+1:W] != 2'b00) ? W'(1) : '0;
      end
      OP_SUBC: begin
        sum2  = {2'b00, b_i} - {2'b00, a_i} + {2'b00, ext_i};
        res_o = sum2[W-1:0];
        ext_o = sum2[W+1] ? '1 : '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_ext_shift.sv
`timescale 1ns/1ps
module alu16_ext_shift
  import alu16_ext_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e       op_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  a_i,
  output logic [W-1:0]  res_o,
  output logic [W-1:0]  ext_o
);

  localparam int W2 = 2 * W;

  function automatic logic [W2-1:0] right_wide(input logic [W-1:0] v, input logic [W-1:0] n,
                                               input logic arith);
    logic signed [W2-1:0] sv;
    logic [W2-1:0]        uv;
    uv = {v, {W{1'b0}}};
    sv = uv;
    return arith ? W2'(sv >>> n) : (uv >> n);
  endfunction

  logic [W2-1:0] wide;

  always_comb begin
    wide  = '0;
    res_o = b_i;
    ext_o = '0;
    unique case (op_i)
      OP_SRL, OP_SRA: begin
        wide  = right_wide(b_i, a_i, op_i == OP_SRA);
        res_o = wide[W2-1:W];
        ext_o = wide[W-1:0];
      end
      OP_SLL: begin
        wide  = {{W{1'b0}}, b_i} << a_i;
        res_o = wide[W-1:0];
        ext_o = wide[W2-1:W];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_ext_cond.sv
`timescale 1ns/1ps
module alu16_ext_cond
  import alu16_ext_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [TST_SEL_W-1:0] sel_i,
  input  logic [W-1:0]         b_i,
  input  logic [W-1:0]         a_i,
  output logic                 hit_o
);

  function automatic logic tst_eval(input logic [TST_SEL_W-1:0] k,
                                    input logic [W-1:0] b, input logic [W-1:0] a);
    case (k)
      3'd0:    return (b & a) != '0;
      3'd1:    return (b & a) == '0;
      3'd2:    return b == a;
      3'd3:    return b != a;
      3'd4:    return b > a;
      3'd5:    return $signed(b) > $signed(a);
      3'd6:    return b < a;
      default: return $signed(b) < $signed(a);
    endcase
  endfunction

  logic [TST_COUNT-1:0] hit_v;

  for (genvar k = 0; k < TST_COUNT; k++) begin : g_tst
    assign hit_v[k] = tst_eval(TST_SEL_W'(k), b_i, a_i);
  end

  assign hit_o = hit_v[sel_i];

endmodule

// File: rtl/alu16_ext.sv
`timescale 1ns/1ps
module alu16_ext
  import alu16_ext_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] ext_i,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output logic [W-1:0] ext_o,
  output logic         ext_we_o,
  output logic         cond_o,
  output logic         idx_up_o,
  output logic         idx_dn_o,
  output logic         illegal_o
);

  alu_op_e       op;
  logic [W-1:0]  ar_res, ar_ext, sh_res, sh_ext;
  logic          zero_div_w;
  logic          tst_hit_w;
  logic          is_test_w;

  assign op        = alu_op_e'(op_i);
  assign is_test_w = (op_i[4:3] == 2'b10);

  alu16_ext_arith #(.W(W)) u_arith (
    .op_i(op), .b_i(b_i), .a_i(a_i), .ext_i(ext_i),
    .res_o(ar_res), .ext_o(ar_ext), .zero_div_o(zero_div_w)
  );

  alu16_ext_shift #(.W(W)) u_shift (
    .op_i(op), .b_i(b_i), .a_i(a_i), .res_o(sh_res), .ext_o(sh_ext)
  );

  alu16_ext_cond #(.W(W)) u_cond (
    .sel_i(op_i[TST_SEL_W-1:0]), .b_i(b_i), .a_i(a_i), .hit_o(tst_hit_w)
  );

  always_comb begin
    res_o     = b_i;
    res_we_o  = 1'b0;
    ext_o     = ext_i;
    ext_we_o  = 1'b0;
    cond_o    = 1'b0;
    idx_up_o  = 1'b0;
    idx_dn_o  = 1'b0;
    illegal_o = 1'b0;
    case (op)
      OP_MOVE, OP_MOVE_UP, OP_MOVE_DN: begin
        res_o    = a_i;
        res_we_o = 1'b1;
        idx_up_o = (op == OP_MOVE_UP);
        idx_dn_o = (op == OP_MOVE_DN);
      end
      OP_ADD, OP_SUB, OP_MULU, OP_MULS, OP_DIVU, OP_DIVS, OP_ADDC, OP_SUBC: begin
        res_o    = ar_res;
        res_we_o = 1'b1;
        ext_o    = ar_ext;
        ext_we_o = 1'b1;
      end
      OP_REMU, OP_REMS: begin
        res_o    = ar_res;
        res_we_o = 1'b1;
      end
      OP_AND: begin res_o = b_i & a_i; res_we_o = 1'b1; end
      OP_OR:  begin res_o = b_i | a_i; res_we_o = 1'b1; end
      OP_XOR: begin res_o = b_i ^ a_i; res_we_o = 1'b1; end
      OP_SRL, OP_SRA, OP_SLL: begin
        res_o    = sh_res;
        res_we_o = 1'b1;
        ext_o    = sh_ext;
        ext_we_o = 1'b1;
      end
      OP_TST_ANY, OP_TST_NON, OP_TST_EQ, OP_TST_NE,
      OP_TST_GTU, OP_TST_GTS, OP_TST_LTU, OP_TST_LTS: cond_o = tst_hit_w;
      OP_RSV_18, OP_RSV_19, OP_RSV_1C, OP_RSV_1D: illegal_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    // R12
    illegal_quiet_chk: assert (!(illegal_o && (res_we_o || ext_we_o || cond_o)));
    // R12
    ext_hold_chk: assert (ext_we_o || (ext_o == ext_i));
    // R1
    idx_onehot_chk: assert ($onehot0({idx_up_o, idx_dn_o}));
    // R11
    cond_scope_chk: assert (!cond_o || (is_test_w && !res_we_o && !ext_we_o));
    // R6
    zero_div_chk: assert (!zero_div_w || (res_we_o && res_o == '0 &&
                          (ext_we_o ? ext_o == '0 : op_i[3])));
    // R2
    add_carry_chk: assert (op != OP_ADD || ext_o == W'(0) || ext_o == W'(1));
    // R2
    sub_borrow_chk: assert (op != OP_SUB || ext_o == '0 || ext_o == '1);
  end

endmodule

// File: tb/alu16_ext_bench.sv
`timescale 1ns/1ps
module alu16_ext_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] b = '0, a = '0, x = '0;
  logic [15:0] res, ext;
  logic        res_we, ext_we, cond, up, dn, ill;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  logic [37:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  alu16_ext u_alu16_ext (
    .op_i(op), .b_i(b), .a_i(a), .ext_i(x),
    .res_o(res), .res_we_o(res_we), .ext_o(ext), .ext_we_o(ext_we),
    .cond_o(cond), .idx_up_o(up), .idx_dn_o(dn), .illegal_o(ill)
  );

  function automatic string req_of(int o);
    case (o)
      1, 30, 31:           return "R1";
      2, 3:                return "R2";
      26, 27:              return "R3";
      4, 5:                return "R4";
      6, 7:                return "R5";
      8, 9:                return "R7";
      10, 11, 12:          return "R8";
      13, 15:              return "R9";
      14:                  return "R10";
      24, 25, 28, 29:      return "R12";
      0:                   return "R13";
      default:             return "R11";
    endcase
  endfunction

  // packed as {res, res_we, ext, ext_we, cond, up, dn, ill}
  function automatic logic [37:0] model(int o, logic [15:0] bb, logic [15:0] aa, logic [15:0] xx);
    logic [15:0] r, e;
    bit rw, ew, c, u, d, il;
    longint lb, la, lx, s, p;
    int sb, sa;
    lb = longint'(bb); la = longint'(aa); lx = longint'(xx);
    sb = int'($signed(bb)); sa = int'($signed(aa));
    r = bb; e = xx; rw = 0; ew = 0; c = 0; u = 0; d = 0; il = 0;
    case (o)
      1:  begin r = aa; rw = 1; end
      30: begin r = aa; rw = 1; u = 1; end
      31: begin r = aa; rw = 1; d = 1; end
      2:  begin s = lb + la; r = s[15:0]; e = (s > 65535) ? 16'h1 : 16'h0; rw = 1; ew = 1; end
      3:  begin s = lb - la; r = s[15:0]; e = (la > lb) ? 16'hFFFF : 16'h0; rw = 1; ew = 1; end
      4:  begin p = lb * la; r = p[15:0]; e = p[31:16]; rw = 1; ew = 1; end
      5:  begin p = longint'(sb) * longint'(sa); r = p[15:0]; e = p[31:16]; rw = 1; ew = 1; end
      6:  begin
            rw = 1; ew = 1;
            if (la == 0) begin r = 0; e = 0; end   // R6
            else begin p = lb / la; r = p[15:0]; p = (lb * 65536) / la; e = p[15:0]; end
          end
      7:  begin
            rw = 1; ew = 1;
            if (la == 0) begin r = 0; e = 0; end   // R6
            else begin
              p = longint'(sb) / longint'(sa); r = p[15:0];
              p = (longint'(sb) * 65536) / longint'(sa); e = p[15:0];
            end
          end
      8:  begin rw = 1; if (la == 0) r = 0; else begin p = lb % la; r = p[15:0]; end end
      9:  begin rw = 1; if (la == 0) r = 0; else begin p = longint'(sb) % longint'(sa); r = p[15:0]; end end
      10: begin r = bb & aa; rw = 1; end
      11: begin r = bb | aa; rw = 1; end
      12: begin r = bb ^ aa; rw = 1; end
      13: begin
            rw = 1; ew = 1;
            if (la >= 16) r = 0; else begin p = lb >> la; r = p[15:0]; end
            if (la >= 32) e = 0; else begin p = (lb * 65536) >> la; e = p[15:0]; end
          end
      14: begin
            rw = 1; ew = 1;
            if (la >= 16) r = (sb < 0) ? 16'hFFFF : 16'h0;
            else begin p = longint'(sb) >>> la; r = p[15:0]; end
            if (la >= 32) e = (sb < 0) ? 16'hFFFF : 16'h0;
            else begin p = (longint'(sb) * 65536) >>> la; e = p[15:0]; end
          end
      15: begin
            rw = 1; ew = 1;
            if (la >= 32) p = 0; else p = lb << la;
            r = p[15:0]; e = p[31:16];
          end
      16: c = (bb & aa) != 0;
      17: c = (bb & aa) == 0;
      18: c = lb == la;
      19: c = lb != la;
      20: c = lb > la;
      21: c = sb > sa;
      22: c = lb < la;
      23: c = sb < sa;
      24, 25, 28, 29: il = 1;
      26: begin s = lb + la + lx; r = s[15:0]; e = (s > 65535) ? 16'h1 : 16'h0; rw = 1; ew = 1; end
      27: begin s = lb - la + lx; r = s[15:0]; e = (s < 0) ? 16'hFFFF : 16'h0; rw = 1; ew = 1; end
      default: ;
    endcase
    return {r, rw, e, ew, c, u, d, il};
  endfunction

  task automatic apply(int o, logic [15:0] bb, logic [15:0] aa, logic [15:0] xx, string tag);
    @(posedge clk);
    #1;
    op = o[4:0]; b = bb; a = aa; x = xx;
    exp_q.push_back(model(o, bb, aa, xx));
    tag_q.push_back(tag);
  endtask

  // monitor: compares one scoreboard item per cycle, half a period after the drive
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [37:0] ev, gv;
      string t;
      ev = exp_q.pop_front();
      t  = tag_q.pop_front();
      gv = {res, res_we, ext, ext_we, cond, up, dn, ill};
      n_checks++;
      if (gv !== ev) begin
        n_err++;
        $display("FAIL %s op=%02h b=%04h a=%04h ext=%04h got=%010h expected=%010h",
                 t, op, b, a, x, gv, ev);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    // R13 quiet outputs while reset is held
    apply(0, 16'h1234, 16'h5678, 16'h9ABC, "R13");
    apply(0, 16'hFFFF, 16'h0000, 16'h0001, "R13");
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1
    apply(1, 16'h1111, 16'hBEEF, 16'h7777, "R1");
    apply(30, 16'h0, 16'h00A5, 16'h1, "R1");
    apply(31, 16'h0, 16'h005A, 16'h2, "R1");
    // R2
    apply(2, 16'hFFFF, 16'h0001, 16'h5555, "R2");
    apply(2, 16'h0001, 16'h0002, 16'h5555, "R2");
    apply(3, 16'h0000, 16'h0001, 16'h0, "R2");
    apply(3, 16'h0005, 16'h0003, 16'hFFFF, "R2");
    // R3
    apply(26, 16'hFFFF, 16'h0000, 16'h0001, "R3");
    apply(26, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R3");
    apply(27, 16'h0000, 16'h0001, 16'h0000, "R3");
    apply(27, 16'hFFFF, 16'h0000, 16'h0001, "R3");
    apply(27, 16'h0003, 16'h0005, 16'hFFFF, "R3");
    // R4
    apply(4, 16'hFFFF, 16'hFFFF, 16'h0, "R4");
    apply(5, 16'hFFFF, 16'h0002, 16'h0, "R4");
    apply(5, 16'h8000, 16'h8000, 16'h0, "R4");
    // R5
    apply(6, 16'h0001, 16'h0002, 16'h0, "R5");
    apply(6, 16'hFFFF, 16'h0003, 16'h0, "R5");
    apply(7, 16'h8000, 16'hFFFF, 16'h0, "R5");
    apply(7, 16'hFFF9, 16'h0002, 16'h0, "R5");
    apply(7, 16'h0007, 16'hFFFE, 16'h0, "R5");
    // R6 zero divisors
    apply(6, 16'h1234, 16'h0000, 16'hAAAA, "R6");
    apply(7, 16'h8000, 16'h0000, 16'hAAAA, "R6");
    apply(8, 16'h0007, 16'h0000, 16'hAAAA, "R6");
    apply(9, 16'hFFF9, 16'h0000, 16'hAAAA, "R6");
    // R7
    apply(8, 16'h0017, 16'h0005, 16'h3333, "R7");
    apply(9, 16'hFFF9, 16'h0010, 16'h3333, "R7");
    apply(9, 16'h0007, 16'hFFFE, 16'h3333, "R7");
    // R8
    apply(10, 16'hF0F0, 16'h0FF0, 16'h4444, "R8");
    apply(11, 16'hF0F0, 16'h0FF0, 16'h4444, "R8");
    apply(12, 16'hF0F0, 16'h0FF0, 16'h4444, "R8");
    // R9 shift boundaries
    for (int i = 0; i < 7; i++) begin
      logic [15:0] cnt [7] = '{16'd0, 16'd4, 16'd15, 16'd16, 16'd31, 16'd32, 16'hFFFF};
      apply(13, 16'hABCD, cnt[i], 16'h0, "R9");
      apply(15, 16'hABCD, cnt[i], 16'h0, "R9");
      apply(14, 16'h8001, cnt[i], 16'h0, "R10");
      apply(14, 16'h7FFE, cnt[i], 16'h0, "R10");
    end
    // R11 each test, true and false cases
    for (int t = 16; t < 24; t++) begin
      apply(t, 16'h0005, 16'h0005, 16'h0, "R11");
      apply(t, 16'hFFFF, 16'h0001, 16'h0, "R11");
      apply(t, 16'h0001, 16'hFFFF, 16'h0, "R11");
      apply(t, 16'h00F0, 16'h000F, 16'h0, "R11");
    end
    // R12 reserved codes pass inputs through
    apply(24, 16'h1357, 16'h2468, 16'h9999, "R12");
    apply(25, 16'h1357, 16'h2468, 16'h9999, "R12");
    apply(28, 16'h1357, 16'h2468, 16'h9999, "R12");
    apply(29, 16'h1357, 16'h2468, 16'h9999, "R12");
    // random sweep, divisor and shift count biased small
    for (int i = 0; i < 3000; i++) begin
      int o;
      logic [15:0] rb, ra, rx;
      o  = i % 32;
      rb = 16'($urandom);
      ra = 16'($urandom);
      rx = 16'($urandom);
      if ((i / 32) % 3 == 1) ra = 16'($urandom_range(0, 40));
      if ((i / 32) % 5 == 2) rb = 16'h8000;
      if ((i / 32) % 7 == 3) ra = 16'hFFFF;
      apply(o, rb, ra, rx, req_of(o));
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule